// File: doc/BRIEF.md
# Edge/Level Interrupt Trigger Control

This block decides, line by line, how sixteen legacy interrupt request inputs become recognised requests. Each input is synchronised, and then either captured on its rising edge into a sticky bit or passed through as a level while it is high. Two byte-wide trigger-mode registers on a small I/O-mapped read/write bus select the behaviour. Only some lines have a trigger-mode bit. The rest are permanently edge-triggered, and their bit positions read back as zero.

The recognised-request vector goes to an interrupt controller core, which handles priority, masking and vectoring. The core returns a per-line acknowledge pulse, and that pulse clears a captured edge.

Top module: `irq_trigger_ctl`

## Requirements
- R1: After reset, both trigger-mode registers read 00h, every line is in edge mode and `irq_req` is all zero.
- R2: The register at address 04D0h controls lines 7..0. Bits 7..3 are writable and set the mode of lines 7..3. Bits 2..0 always read 0, and writing them has no effect.
- R3: The register at address 04D1h controls lines 15..8. Bits 7, 6, 4, 3, 2 and 1 are writable and set the mode of lines 15, 14, 12, 11, 10 and 9. Bits 5 and 0 always read 0, and writing them has no effect. The combined writable mask over lines 15..0 is DEF8h.
- R4: A read returns the addressed register on `bus_rdata` one clock after `bus_rd` is sampled high. A read of any other address, or a clock with `bus_rd` low, gives 00h. A write to any other address changes no register.
- R5: Each request input passes through two synchroniser flops. A change on `irq_in` reaches `irq_req` at the third rising clock edge after it is sampled, and not before.
- R6: A line whose mode bit is 0 sets its `irq_req` bit on a low-to-high transition of its input. The bit stays set after the input falls.
- R7: An acknowledge pulse on an edge-mode line clears its `irq_req` bit at the next clock edge, unless a new edge arrives in that same cycle.
- R8: When a new rising edge and an acknowledge reach an edge-mode line in the same cycle, the line stays requested.
- R9: A line whose mode bit is 1 has `irq_req` equal to its synchronised input, high while the input is high. The acknowledge has no lasting effect on it.
- R10: Switching a line from edge mode to level mode discards its captured edge. Switching it back to edge mode does not restore the captured edge.
- R11: Lines 13, 8, 2, 1 and 0 stay edge-triggered even when ones are written to both registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | I/O address of the access |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_in | input | 16 | Raw asynchronous request inputs |
| irq_ack | input | 16 | Per-line acknowledge pulses |
| irq_req | output | 16 | Registered recognised-request vector |

## Verification
On every clock, the bound checker confirms four things. Stored mode bits take the masked write data. Fixed bit positions and unmatched addresses read as zero. A level-mode line mirrors its input three cycles late. A fixed edge line rises only after a sampled low-to-high input and drops after an acknowledge that arrives with no fresh edge. Some behaviours span several bus and input events, and only the bench scenarios show them. These are the full register sweeps, the edge-beats-acknowledge collision, and the loss of a captured edge across an edge-to-level-to-edge mode round trip.

// File: rtl/irq_trig_pkg.sv
package irq_trig_pkg;
  localparam int unsigned LINES_DEF = 16;
  localparam int unsigned REG_W_DEF = 8;
  localparam int unsigned ADDR_W_DEF = 16;
  localparam logic [15:0] BASE_DEF = 16'h04D0;
  // one bit per line: 1 = mode bit exists, 0 = line fixed to edge
  localparam logic [15:0] MASK_DEF = 16'hDEF8;
endpackage

// File: rtl/trig_mode_regs.sv
module trig_mode_regs #(
  parameter int unsigned N_LINES = 16,
  parameter int unsigned REG_W = 8,
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h04D0,
  parameter logic [N_LINES-1:0] MODE_MASK = 16'hDEF8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr,
  input  logic               rd,
  input  logic [REG_W-1:0]   wdata,
  output logic [REG_W-1:0]   rdata,
  output logic [N_LINES-1:0] mode
);
  localparam int unsigned N_REGS = N_LINES / REG_W;

  logic [N_REGS-1:0] hit;
  logic [REG_W-1:0]  rd_mux;

  for (genvar r = 0; r < N_REGS; r++) begin : g_dec
    localparam logic [ADDR_W-1:0] REG_ADDR = BASE_ADDR + ADDR_W'(r);
    assign hit[r] = (addr == REG_ADDR);
  end

  // fixed positions are masked at write time, so they stay constant zero
  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= '0;
    end else if (wr) begin
      for (int r = 0; r < N_REGS; r++) begin
        if (hit[r]) begin
          mode[r*REG_W +: REG_W] <= wdata & MODE_MASK[r*REG_W +: REG_W];
        end
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int r = 0; r < N_REGS; r++) begin
      if (hit[r]) rd_mux = mode[r*REG_W +: REG_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd ? rd_mux : '0;
  end
endmodule

// File: rtl/irq_sync_2ff.sv
module irq_sync_2ff #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/irq_line_detect.sv
module irq_line_detect (
  input  logic clk,
  input  logic rst,
  input  logic level_mode,
  input  logic sync_in,
  input  logic ack,
  output logic req
);
  logic prev_q;
  logic sticky_q;
  logic rise;
  logic sticky_nxt;

  assign rise = sync_in & ~prev_q;
  // a fresh edge outranks a simultaneous acknowledge
  assign sticky_nxt = rise | (sticky_q & ~ack);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= 1'b0;
      sticky_q <= 1'b0;
      req      <= 1'b0;
    end else begin
      prev_q <= sync_in;
      if (level_mode) begin
        sticky_q <= 1'b0;
        req      <= sync_in;
      end else begin
        sticky_q <= sticky_nxt;
        req      <= sticky_nxt;
      end
    end
  end
endmodule

// File: rtl/irq_trigger_ctl.sv
module irq_trigger_ctl
  import irq_trig_pkg::*;
#(
  parameter int unsigned N_LINES = LINES_DEF,
  parameter int unsigned REG_W = REG_W_DEF,
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  parameter logic [ADDR_W-1:0] BASE_ADDR = BASE_DEF,
  parameter logic [N_LINES-1:0] MODE_MASK = MASK_DEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [REG_W-1:0]   bus_wdata,
  output logic [REG_W-1:0]   bus_rdata,
  input  logic [N_LINES-1:0] irq_in,
  input  logic [N_LINES-1:0] irq_ack,
  output logic [N_LINES-1:0] irq_req
);
  logic [N_LINES-1:0] trig_mode;
  logic [N_LINES-1:0] irq_sync;

  trig_mode_regs #(
    .N_LINES(N_LINES), .REG_W(REG_W), .ADDR_W(ADDR_W),
    .BASE_ADDR(BASE_ADDR), .MODE_MASK(MODE_MASK)
  ) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wdata(bus_wdata), .rdata(bus_rdata), .mode(trig_mode)
  );

  irq_sync_2ff #(.W(N_LINES)) u_sync (
    .clk(clk), .rst(rst), .d(irq_in), .q(irq_sync)
  );

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    logic lvl;
    if (MODE_MASK[i]) begin : g_sel
      assign lvl = trig_mode[i];
    end else begin : g_fixed
      assign lvl = 1'b0;
    end
    irq_line_detect u_det (
      .clk(clk), .rst(rst), .level_mode(lvl), .sync_in(irq_sync[i]),
      .ack(irq_ack[i]), .req(irq_req[i])
    );
  end
endmodule

// File: rtl/irq_trigger_ctl_chk.sv
module irq_trigger_ctl_chk #(
  parameter int unsigned N_LINES = 16,
  parameter int unsigned REG_W = 8,
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h04D0,
  parameter logic [N_LINES-1:0] MODE_MASK = 16'hDEF8
) (
  input logic               clk,
  input logic               rst,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic [REG_W-1:0]   bus_wdata,
  input logic [REG_W-1:0]   bus_rdata,
  input logic [N_LINES-1:0] irq_in,
  input logic [N_LINES-1:0] irq_ack,
  input logic [N_LINES-1:0] irq_req,
  input logic [N_LINES-1:0] trig_mode
);
  localparam int unsigned N_REGS = N_LINES / REG_W;

  logic [2:0] age;
  logic settled;
  logic any_hit;

  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (age != 3'd7) age <= age + 3'd1;
  end
  assign settled = (age >= 3'd4);

  always_comb begin
    any_hit = 1'b0;
    for (int r = 0; r < N_REGS; r++) begin
      if (bus_addr == BASE_ADDR + ADDR_W'(r)) any_hit = 1'b1;
    end
  end

  assert_miss_reads_zero_R4: assert property (@(posedge clk) disable iff (rst)
    settled && $past(bus_rd) && !$past(any_hit) |-> bus_rdata == '0);

  for (genvar r = 0; r < N_REGS; r++) begin : g_reg
    localparam logic [ADDR_W-1:0] REG_ADDR = BASE_ADDR + ADDR_W'(r);
    localparam logic [REG_W-1:0]  WMASK = MODE_MASK[r*REG_W +: REG_W];

    assert_mode_write_R2_R3: assert property (@(posedge clk) disable iff (rst)
      settled && $past(bus_wr) && $past(bus_addr) == REG_ADDR
      |-> trig_mode[r*REG_W +: REG_W] == ($past(bus_wdata) & WMASK));

    assert_rsvd_zero_R2_R3: assert property (@(posedge clk) disable iff (rst)
      settled && $past(bus_rd) && $past(bus_addr) == REG_ADDR
      |-> (bus_rdata & ~WMASK) == '0);
  end

  for (genvar i = 0; i < N_LINES; i++) begin : g_ln
    if (MODE_MASK[i]) begin : g_sel
      assert_level_follow_R9: assert property (@(posedge clk) disable iff (rst)
        settled && $past(trig_mode[i]) |-> irq_req[i] == $past(irq_in[i], 3));
    end else begin : g_fixed
      assert_fixed_rise_R11: assert property (@(posedge clk) disable iff (rst)
        settled && $rose(irq_req[i])
        |-> $past(irq_in[i], 3) && !$past(irq_in[i], 4));

      assert_ack_clears_R7: assert property (@(posedge clk) disable iff (rst)
        settled && $past(irq_ack[i]) && !($past(irq_in[i], 3) && !$past(irq_in[i], 4))
        |-> !irq_req[i]);
    end
  end
endmodule

bind irq_trigger_ctl irq_trigger_ctl_chk #(
  .N_LINES(N_LINES), .REG_W(REG_W), .ADDR_W(ADDR_W),
  .BASE_ADDR(BASE_ADDR), .MODE_MASK(MODE_MASK)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
  .irq_ack(irq_ack), .irq_req(irq_req), .trig_mode(trig_mode)
);

// File: tb/irq_trigger_ctl_tb.sv
`timescale 1ns/1ps
module irq_trigger_ctl_tb;
  localparam logic [15:0] LO_ADDR = 16'h04D0;
  localparam logic [15:0] HI_ADDR = 16'h04D1;
  localparam logic [15:0] WMASK   = 16'hDEF8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [15:0] irq_in = '0;
  logic [15:0] irq_ack = '0;
  logic [15:0] irq_req;

  int n_vec = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  irq_trigger_ctl u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
    .irq_ack(irq_ack), .irq_req(irq_req)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [15:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick(1);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [15:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    tick(1);
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic ack_all();
    irq_ack = 16'hFFFF;
    tick(1);
    irq_ack = '0;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] rv;
    tick(4);
    rst = 1'b0;
    tick(1);

    // R1 reset state
    chk("R1 req", irq_req, 16'h0000);
    rd_reg(LO_ADDR, rv); chk("R1 lo", {8'h0, rv}, 16'h0000);
    rd_reg(HI_ADDR, rv); chk("R1 hi", {8'h0, rv}, 16'h0000);

    // R2 / R3 exhaustive write and read-back sweep
    for (int v = 0; v < 256; v++) begin
      wr_reg(LO_ADDR, 8'(v));
      rd_reg(LO_ADDR, rv); chk("R2 lo readback", {8'h0, rv}, {8'h0, 8'(v) & WMASK[7:0]});
      wr_reg(HI_ADDR, 8'(255 - v));
      rd_reg(HI_ADDR, rv); chk("R3 hi readback", {8'h0, rv}, {8'h0, 8'(255 - v) & WMASK[15:8]});
      rd_reg(LO_ADDR, rv); chk("R2 lo kept", {8'h0, rv}, {8'h0, 8'(v) & WMASK[7:0]});
    end

    // R4 foreign addresses: writes ignored, reads zero, rd low gives zero
    wr_reg(LO_ADDR, 8'hFF); wr_reg(HI_ADDR, 8'hFF);
    wr_reg(16'h04D2, 8'h00); wr_reg(16'h05D0, 8'h00); wr_reg(16'h04CF, 8'h00);
    rd_reg(LO_ADDR, rv); chk("R4 lo untouched", {8'h0, rv}, 16'h00F8);
    rd_reg(HI_ADDR, rv); chk("R4 hi untouched", {8'h0, rv}, 16'h00DE);
    rd_reg(16'h04D2, rv); chk("R4 miss read", {8'h0, rv}, 16'h0000);
    bus_addr = LO_ADDR; tick(1); chk("R4 idle rdata", {8'h0, bus_rdata}, 16'h0000);

    // per-line edge mode sweep: R5 latency, R6 sticky, R7 ack
    wr_reg(LO_ADDR, 8'h00); wr_reg(HI_ADDR, 8'h00);
    tick(4); ack_all();
    for (int i = 0; i < 16; i++) begin
      irq_in = 16'h1 << i;
      tick(2); chk("R5 not yet", irq_req, 16'h0000);
      tick(1); chk("R6 edge set", irq_req, 16'h1 << i);
      irq_in = '0;
      tick(3); chk("R6 sticky", irq_req, 16'h1 << i);
      irq_ack = 16'h1 << i;
      tick(1); irq_ack = '0;
      chk("R7 ack clear", irq_req, 16'h0000);
    end

    // per-line level mode sweep: R9 level, R11 fixed lines
    wr_reg(LO_ADDR, 8'hFF); wr_reg(HI_ADDR, 8'hFF);
    tick(3);
    for (int i = 0; i < 16; i++) begin
      irq_in = 16'h1 << i;
      tick(3); chk("R9/R11 assert", irq_req, 16'h1 << i);
      irq_ack = 16'h1 << i;
      tick(1); irq_ack = '0;
      chk("R9/R11 ack", irq_req, (16'h1 << i) & WMASK);
      irq_in = '0;
      tick(3); chk("R9 drop", irq_req, 16'h0000);
    end
    irq_in = 16'hFFFF; tick(3); chk("R9 all high", irq_req, 16'hFFFF);
    irq_in = 16'h0000; tick(3); chk("R11 fixed sticky", irq_req, ~WMASK);
    ack_all(); chk("R7 fixed ack", irq_req, 16'h0000);

    // R8 edge beats ack
    wr_reg(LO_ADDR, 8'h00); wr_reg(HI_ADDR, 8'h00);
    irq_in = 16'hFFFF; tick(3); chk("R6 all edges", irq_req, 16'hFFFF);
    irq_in = 16'h0000; tick(3); chk("R6 all sticky", irq_req, 16'hFFFF);
    irq_in = 16'hFFFF; tick(2);
    irq_ack = 16'hFFFF; tick(1); irq_ack = '0;
    chk("R8 edge wins", irq_req, 16'hFFFF);
    ack_all(); chk("R7 ack no edge", irq_req, 16'h0000);

    // R10 edge -> level -> edge drops captured edges
    irq_in = 16'h0000; tick(3);
    irq_in = 16'hFFFF; tick(3);
    irq_in = 16'h0000; tick(3); chk("R10 captured", irq_req, 16'hFFFF);
    wr_reg(LO_ADDR, 8'hFF); wr_reg(HI_ADDR, 8'hFF); tick(1);
    chk("R10 level low", irq_req, ~WMASK);
    wr_reg(LO_ADDR, 8'h00); wr_reg(HI_ADDR, 8'h00); tick(1);
    chk("R10 not restored", irq_req, ~WMASK);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule